// File: doc/BRIEF.md
# Inbound Request Dispatcher

This block sits behind the transaction-layer parser of a PCI Express endpoint. Each cycle it may take one decoded request header: a type code, the requester ID, tag, attribute bits and byte enables. For each request it reports which flow-control credit classes the request uses. It sends the request to one of four internal clients: configuration space, the register file, the DMA engine, or the message/interrupt/power/error unit. Type codes it does not support are flagged and dropped.

When a request needs an answer, the block saves the requester context in a small in-order table. A client supplies read data, or an acknowledge for writes, on a shared response port. The block then emits a completion record that carries the saved requester ID, tag and attribute bits, and the read data when the completion carries data.

A request whose byte enables are all zero touches no client. A zero-length write has no effect. A zero-length read is still answered, with zero data. Any non-zero byte-enable pattern is dispatched as a full access. New requests that need a completion are held off while the table is full. Posted traffic keeps flowing.

Top module: `inbound_req_dispatcher`

## Requirements
- R1: An accepted request pulses `credit_valid` one cycle later, with `credit_mask` bits 0..5 = posted header, posted data, non-posted header, non-posted data, completion header, completion data. Config read, memory read and I/O read use only bit 2. Config write and I/O write use bits 2 and 3. Memory write uses bits 0 and 1. Read completion uses bits 4 and 5. Message uses bit 0.
- R2: Type codes are 0 config read, 1 config write, 2 memory read, 3 memory write, 4 I/O read, 5 I/O write, 6 read completion, 7 message. An accepted request pulses `disp_valid` one cycle later with `disp_dest`: 0 config space for codes 0 and 1, 1 register file for codes 2 to 5, 2 DMA for code 6, 3 message unit for code 7. `disp_write` is 1 exactly for codes 1, 3 and 5.
- R3: Codes 0, 2 and 4 produce a completion with `cpl_has_data`=1. Codes 1 and 5 produce one with `cpl_has_data`=0 and `cpl_data`=0. Codes 3, 6 and 7 produce no completion.
- R4: A completion carries the requester ID, tag and attribute bits of the request that caused it. For a dispatched read it carries the `rsp_data` value supplied on the response cycle. It appears one cycle after that response.
- R5: Completions leave in the order their requests were accepted. A later request is never answered before an earlier one, including a zero-length one.
- R6: With DEPTH completions outstanding, `in_ready` is low while `in_kind` is a completion-needing code (0,1,2,4,5). It stays high for codes 3, 6, 7 and for unsupported codes, and such requests are accepted.
- R7: Codes 8 to 15 pulse `err_unsupported` one cycle after acceptance. They produce no credit pulse, no dispatch and no completion.
- R8: For codes 0 to 5 with `in_be`=0 there is no dispatch, but credits are still reported. For codes 0, 1, 2, 4 and 5 a completion is still issued once the request reaches the head of the table, with zero data. For codes 6 and 7 the byte enables are ignored.
- R9: For codes 0 to 5, any non-zero `in_be` is dispatched exactly as a full access.
- R10: `rsp_valid` while no completion is outstanding produces no completion.
- R11: After reset all output pulses are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request header present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_kind | input | 4 | Request type code |
| in_rid | input | RID_W | Requester ID |
| in_tag | input | TAG_W | Requester tag |
| in_attr | input | ATTR_W | Attribute bits |
| in_be | input | BE_W | Byte enables |
| credit_valid | output | 1 | Credit report pulse |
| credit_mask | output | 6 | Credit classes consumed |
| disp_valid | output | 1 | Client dispatch pulse |
| disp_dest | output | 2 | Target client |
| disp_write | output | 1 | Dispatch is a write |
| err_unsupported | output | 1 | Unsupported type dropped |
| rsp_valid | input | 1 | Client response for the oldest outstanding request |
| rsp_data | input | DATA_W | Client read data |
| cpl_valid | output | 1 | Completion record pulse |
| cpl_rid | output | RID_W | Saved requester ID |
| cpl_tag | output | TAG_W | Saved tag |
| cpl_attr | output | ATTR_W | Saved attributes |
| cpl_has_data | output | 1 | Completion carries data |
| cpl_data | output | DATA_W | Completion payload |

## Verification
The bench targets zero-length accesses. A design that ignored the byte enables would wrongly dispatch to a client, and one that answered such a read at once would jump ahead of an older pending read and break order. It fills the context table to check that only completion-needing codes stall. A design that stalled everything would lock up posted writes, and one that never stalled would overwrite saved tags. It also sends a stray client response on an empty table and unsupported codes, either of which a careless design would turn into phantom completions or dispatches.

// File: rtl/ird_pkg.sv
package ird_pkg;

    typedef enum logic [3:0] {
        K_CFG_RD = 4'd0,
        K_CFG_WR = 4'd1,
        K_MEM_RD = 4'd2,
        K_MEM_WR = 4'd3,
        K_IO_RD  = 4'd4,
        K_IO_WR  = 4'd5,
        K_RD_CPL = 4'd6,
        K_MSG    = 4'd7
    } kind_e;

    typedef enum logic [1:0] {
        DST_CFG = 2'd0,
        DST_REG = 2'd1,
        DST_DMA = 2'd2,
        DST_MSG = 2'd3
    } dest_e;

    localparam int CR_W     = 6;
    localparam int CR_PHDR  = 0;
    localparam int CR_PDAT  = 1;
    localparam int CR_NPHDR = 2;
    localparam int CR_NPDAT = 3;
    localparam int CR_CHDR  = 4;
    localparam int CR_CDAT  = 5;

    typedef struct packed {
        logic [CR_W-1:0] credits;
        dest_e           dest;
        logic            is_write;
        logic            needs_cpl;
        logic            cpl_data;
        logic            be_matters;
        logic            bad;
    } class_t;

endpackage

// File: rtl/ird_classify.sv
module ird_classify
    import ird_pkg::*;
(
    input  logic [3:0] kind,
    output class_t     cls
);

    always_comb begin
        cls = '0;
        cls.dest = DST_CFG;
        case (kind_e'(kind))
            K_CFG_RD: begin
                cls.credits[CR_NPHDR] = 1'b1;
                cls.needs_cpl = 1'b1;
                cls.cpl_data = 1'b1;
                cls.be_matters = 1'b1;
            end
            K_CFG_WR: begin
                cls.credits[CR_NPHDR] = 1'b1;
                cls.credits[CR_NPDAT] = 1'b1;
                cls.is_write = 1'b1;
                cls.needs_cpl = 1'b1;
                cls.be_matters = 1'b1;
            end
            K_MEM_RD, K_IO_RD: begin
                cls.credits[CR_NPHDR] = 1'b1;
                cls.dest = DST_REG;
                cls.needs_cpl = 1'b1;
                cls.cpl_data = 1'b1;
                cls.be_matters = 1'b1;
            end
            K_MEM_WR: begin
                cls.credits[CR_PHDR] = 1'b1;
                cls.credits[CR_PDAT] = 1'b1;
                cls.dest = DST_REG;
                cls.is_write = 1'b1;
                cls.be_matters = 1'b1;
            end
            K_IO_WR: begin
                cls.credits[CR_NPHDR] = 1'b1;
                cls.credits[CR_NPDAT] = 1'b1;
                cls.dest = DST_REG;
                cls.is_write = 1'b1;
                cls.needs_cpl = 1'b1;
                cls.be_matters = 1'b1;
            end
            K_RD_CPL: begin
                cls.credits[CR_CHDR] = 1'b1;
                cls.credits[CR_CDAT] = 1'b1;
                cls.dest = DST_DMA;
            end
            K_MSG: begin
                cls.credits[CR_PHDR] = 1'b1;
                cls.dest = DST_MSG;
            end
            default: begin
                cls.bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ird_ctx_table.sv
module ird_ctx_table #(
    parameter int ENTRY_W = 28,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_entry,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head_entry,
    output logic               head_valid,
    output logic               full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ENTRY_W-1:0] slots;
        logic [PTR_W-1:0]              wr;
        logic [PTR_W-1:0]              rd;
        logic [CNT_W-1:0]              cnt;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        tbl_d = tbl_q;
        if (push) begin
            tbl_d.slots[tbl_q.wr] = push_entry;
            tbl_d.wr = bump(tbl_q.wr);
        end
        if (pop) begin
            tbl_d.rd = bump(tbl_q.rd);
        end
        case ({push, pop})
            2'b10:   tbl_d.cnt = tbl_q.cnt + 1'b1;
            2'b01:   tbl_d.cnt = tbl_q.cnt - 1'b1;
            default: tbl_d.cnt = tbl_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign head_entry = tbl_q.slots[tbl_q.rd];
    assign head_valid = (tbl_q.cnt != '0);
    assign full       = (tbl_q.cnt == CNT_W'(DEPTH));

    // R6
    push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R5
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_q.cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/inbound_req_dispatcher.sv
module inbound_req_dispatcher
    import ird_pkg::*;
#(
    parameter int RID_W  = 16,
    parameter int TAG_W  = 8,
    parameter int ATTR_W = 2,
    parameter int BE_W   = 4,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [3:0]        in_kind,
    input  logic [RID_W-1:0]  in_rid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [ATTR_W-1:0] in_attr,
    input  logic [BE_W-1:0]   in_be,
    output logic              credit_valid,
    output logic [CR_W-1:0]   credit_mask,
    output logic              disp_valid,
    output logic [1:0]        disp_dest,
    output logic              disp_write,
    output logic              err_unsupported,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              cpl_valid,
    output logic [RID_W-1:0]  cpl_rid,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [ATTR_W-1:0] cpl_attr,
    output logic              cpl_has_data,
    output logic [DATA_W-1:0] cpl_data
);

    localparam int ENTRY_W = RID_W + TAG_W + ATTR_W + 2;

    typedef struct packed {
        logic [RID_W-1:0]  rid;
        logic [TAG_W-1:0]  tag;
        logic [ATTR_W-1:0] attr;
        logic              with_data;
        logic              no_access;
    } ctx_t;

    typedef struct packed {
        logic              credit_valid;
        logic [CR_W-1:0]   credit_mask;
        logic              disp_valid;
        dest_e             disp_dest;
        logic              disp_write;
        logic              err;
        logic              cpl_valid;
        logic [RID_W-1:0]  cpl_rid;
        logic [TAG_W-1:0]  cpl_tag;
        logic [ATTR_W-1:0] cpl_attr;
        logic              cpl_has_data;
        logic [DATA_W-1:0] cpl_data;
    } out_t;

    class_t cls;
    ctx_t   push_ctx, head_ctx;
    logic   tbl_full, head_valid, accept, zero_len, push, pop;
    logic [ENTRY_W-1:0] head_raw;
    out_t   st_d, st_q;

    ird_classify i_classify (
        .kind (in_kind),
        .cls  (cls)
    );

    ird_ctx_table #(
        .ENTRY_W (ENTRY_W),
        .DEPTH   (DEPTH)
    ) i_ctx_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_ctx),
        .pop        (pop),
        .head_entry (head_raw),
        .head_valid (head_valid),
        .full       (tbl_full)
    );

    assign head_ctx = ctx_t'(head_raw);
    assign in_ready = !tbl_full || !cls.needs_cpl;
    assign accept   = in_valid && in_ready;
    assign zero_len = cls.be_matters && (in_be == '0);
    assign push     = accept && !cls.bad && cls.needs_cpl;
    assign pop      = head_valid && (head_ctx.no_access || rsp_valid);

    always_comb begin
        push_ctx.rid       = in_rid;
        push_ctx.tag       = in_tag;
        push_ctx.attr      = in_attr;
        push_ctx.with_data = cls.cpl_data;
        push_ctx.no_access = zero_len;
    end

    always_comb begin
        st_d = '0;
        st_d.disp_dest    = cls.dest;
        st_d.credit_valid = accept && !cls.bad;
        st_d.credit_mask  = (accept && !cls.bad) ? cls.credits : '0;
        st_d.disp_valid   = accept && !cls.bad && !zero_len;
        st_d.disp_write   = cls.is_write;
        st_d.err          = accept && cls.bad;
        st_d.cpl_valid    = pop;
        if (pop) begin
            st_d.cpl_rid      = head_ctx.rid;
            st_d.cpl_tag      = head_ctx.tag;
            st_d.cpl_attr     = head_ctx.attr;
            st_d.cpl_has_data = head_ctx.with_data;
            st_d.cpl_data     = (head_ctx.with_data && !head_ctx.no_access)
                                ? rsp_data : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign credit_valid    = st_q.credit_valid;
    assign credit_mask     = st_q.credit_mask;
    assign disp_valid      = st_q.disp_valid;
    assign disp_dest       = st_q.disp_dest;
    assign disp_write      = st_q.disp_write;
    assign err_unsupported = st_q.err;
    assign cpl_valid       = st_q.cpl_valid;
    assign cpl_rid         = st_q.cpl_rid;
    assign cpl_tag         = st_q.cpl_tag;
    assign cpl_attr        = st_q.cpl_attr;
    assign cpl_has_data    = st_q.cpl_has_data;
    assign cpl_data        = st_q.cpl_data;

    // R7
    bad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_unsupported |-> !credit_valid && !disp_valid);

    // R3
    nodata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_has_data |-> cpl_data == '0);

    // R1
    credit_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        credit_valid |-> credit_mask != '0 && $countones(credit_mask) <= 2);

    // R10
    stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !head_valid |=> !cpl_valid);

    // R8
    zero_nodisp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_be == '0 && in_kind <= 4'd5 |=> !disp_valid);

endmodule

// File: tb/test_inbound_req_dispatcher.sv
module test_inbound_req_dispatcher;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int NVEC = 19;

    // {kind, be, credit mask, dest, disp, cpl, has_data, err}
    localparam logic [19:0] VEC [NVEC] = '{
        {4'd0,  4'hF, 6'b000100, 2'd0, 4'b1110},
        {4'd1,  4'hF, 6'b001100, 2'd0, 4'b1100},
        {4'd2,  4'hF, 6'b000100, 2'd1, 4'b1110},
        {4'd3,  4'hF, 6'b000011, 2'd1, 4'b1000},
        {4'd4,  4'hF, 6'b000100, 2'd1, 4'b1110},
        {4'd5,  4'hF, 6'b001100, 2'd1, 4'b1100},
        {4'd6,  4'hF, 6'b110000, 2'd2, 4'b1000},
        {4'd7,  4'hF, 6'b000001, 2'd3, 4'b1000},
        {4'd9,  4'hF, 6'b000000, 2'd0, 4'b0001},
        {4'd15, 4'h3, 6'b000000, 2'd0, 4'b0001},
        {4'd2,  4'h1, 6'b000100, 2'd1, 4'b1110},
        {4'd3,  4'h4, 6'b000011, 2'd1, 4'b1000},
        {4'd3,  4'h0, 6'b000011, 2'd1, 4'b0000},
        {4'd2,  4'h0, 6'b000100, 2'd1, 4'b0110},
        {4'd5,  4'h0, 6'b001100, 2'd1, 4'b0100},
        {4'd0,  4'h0, 6'b000100, 2'd0, 4'b0110},
        {4'd1,  4'h0, 6'b001100, 2'd0, 4'b0100},
        {4'd6,  4'h0, 6'b110000, 2'd2, 4'b1000},
        {4'd7,  4'h0, 6'b000001, 2'd3, 4'b1000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [3:0] in_kind = '0;
    logic [15:0] in_rid = '0;
    logic [7:0] in_tag = '0;
    logic [1:0] in_attr = '0;
    logic [3:0] in_be = '0;
    logic credit_valid, disp_valid, disp_write, err_unsupported;
    logic [5:0] credit_mask;
    logic [1:0] disp_dest;
    logic rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic cpl_valid, cpl_has_data;
    logic [15:0] cpl_rid;
    logic [7:0] cpl_tag;
    logic [1:0] cpl_attr;
    logic [31:0] cpl_data;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inbound_req_dispatcher #(.DEPTH(DEPTH)) i_inbound_req_dispatcher (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_rid(in_rid), .in_tag(in_tag), .in_attr(in_attr),
        .in_be(in_be), .credit_valid(credit_valid), .credit_mask(credit_mask),
        .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_write(disp_write),
        .err_unsupported(err_unsupported), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .cpl_valid(cpl_valid), .cpl_rid(cpl_rid), .cpl_tag(cpl_tag), .cpl_attr(cpl_attr),
        .cpl_has_data(cpl_has_data), .cpl_data(cpl_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at a negedge; returns at the next negedge with in_valid low.
    task automatic send(input logic [3:0] k, input logic [3:0] be,
                        input logic [15:0] rid, input logic [7:0] tag, input logic [1:0] attr);
        in_kind = k; in_be = be; in_rid = rid; in_tag = tag; in_attr = attr;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic respond(input logic [31:0] d);
        rsp_valid = 1'b1; rsp_data = d;
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        check("R11 in_ready", in_ready, 1);
        check("R11 pulses", {credit_valid, disp_valid, err_unsupported, cpl_valid}, 0);

        // R10 stray response on empty table
        respond(32'hDEAD_BEEF);
        @(posedge clk); @(negedge clk);
        check("R10 stray rsp cpl_valid", cpl_valid, 0);

        // Table walk: R1 R2 R3 R4 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] k, be;
            logic [5:0] mask;
            logic [1:0] dst;
            logic e_disp, e_cpl, e_hd, e_err, e_wr;
            logic [15:0] rid;
            logic [7:0] tag;
            logic [1:0] attr;
            logic [31:0] rd;
            {k, be, mask, dst, e_disp, e_cpl, e_hd, e_err} = VEC[i];
            e_wr = (k == 4'd1) || (k == 4'd3) || (k == 4'd5);
            rid = 16'h1000 + 16'(i * 7);
            tag = 8'(i * 3 + 1);
            attr = 2'(i);
            rd = 32'hA500_0000 + 32'(i);
            in_kind = k; #1;
            check("R6 ready empty table", in_ready, 1);
            send(k, be, rid, tag, attr);
            check("R1 credit_valid", credit_valid, !e_err);
            check("R1 credit_mask", credit_mask, mask);
            check("R7 err_unsupported", err_unsupported, e_err);
            check("R8/R9 disp_valid", disp_valid, e_disp);
            if (e_disp) begin
                check("R2 disp_dest", disp_dest, dst);
                check("R2 disp_write", disp_write, e_wr);
            end
            if (e_disp && e_cpl) begin
                respond(rd);
            end else begin
                @(posedge clk); @(negedge clk);
            end
            check("R3 cpl_valid", cpl_valid, e_cpl);
            if (e_cpl) begin
                check("R4 cpl_rid", cpl_rid, rid);
                check("R4 cpl_tag", cpl_tag, tag);
                check("R4 cpl_attr", cpl_attr, attr);
                check("R3 cpl_has_data", cpl_has_data, e_hd);
                check("R4/R8 cpl_data", cpl_data, (e_disp && e_hd) ? rd : 32'h0);
            end
        end

        // R6 fill the table with memory reads
        for (int j = 0; j < DEPTH; j++) begin
            in_kind = 4'd2; #1;
            check("R6 ready before full", in_ready, 1);
            send(4'd2, 4'hF, 16'h2200 + 16'(j), 8'h40 + 8'(j), 2'(j));
        end
        in_kind = 4'd2; in_valid = 1'b1; #1;
        check("R6 mem read stalled", in_ready, 0);
        in_kind = 4'd5; #1;
        check("R6 io write stalled", in_ready, 0);
        in_kind = 4'd0; #1;
        check("R6 cfg read stalled", in_ready, 0);
        @(posedge clk); @(negedge clk);
        check("R6 no dispatch while stalled", disp_valid, 0);
        in_valid = 1'b0;
        in_kind = 4'd3; #1;
        check("R6 posted write ready when full", in_ready, 1);
        send(4'd3, 4'hF, 16'h3333, 8'h99, 2'd0);
        check("R6 posted write dispatched", disp_valid, 1);
        in_kind = 4'd7; #1;
        check("R6 message ready when full", in_ready, 1);

        // R5 drain in order
        for (int j = 0; j < DEPTH; j++) begin
            respond(32'hC000_0000 + 32'(j));
            check("R5 cpl_valid", cpl_valid, 1);
            check("R5 cpl_tag order", cpl_tag, 8'h40 + 8'(j));
            check("R5 cpl_rid order", cpl_rid, 16'h2200 + 16'(j));
            check("R4 cpl_data", cpl_data, 32'hC000_0000 + 32'(j));
        end
        in_kind = 4'd2; #1;
        check("R6 ready after drain", in_ready, 1);

        // R5 zero-length read waits behind an older pending read
        send(4'd2, 4'hF, 16'h5151, 8'h77, 2'd1);
        send(4'd2, 4'h0, 16'h5252, 8'h78, 2'd2);
        check("R8 zero-length read not dispatched", disp_valid, 0);
        check("R5 no early cpl", cpl_valid, 0);
        @(posedge clk); @(negedge clk);
        check("R5 no early cpl later", cpl_valid, 0);
        respond(32'h1234_5678);
        check("R5 older first valid", cpl_valid, 1);
        check("R5 older first tag", cpl_tag, 8'h77);
        check("R4 older data", cpl_data, 32'h1234_5678);
        @(posedge clk); @(negedge clk);
        check("R5 younger next valid", cpl_valid, 1);
        check("R5 younger next tag", cpl_tag, 8'h78);
        check("R8 zero-length data", cpl_data, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R5 no extra cpl", cpl_valid, 0);

        finish_run();
    end

endmodule